// File: doc/BRIEF.md
# Trace Cache with Retire-Side Fill Unit

This block holds short dynamic instruction sequences, called traces, so that a fetch front end can obtain several consecutive basic blocks in a single access. A trace is keyed by the address of its first instruction and also records the direction each conditional branch inside it actually took. Instructions enter the block on the retire side, one per cycle, each with flags for "conditional branch", "taken", and "trace-ending jump". The last flag marks an indirect jump or a return. The fill unit gathers these instructions into a trace and writes the finished trace into a direct-mapped store of 32 lines. The line index is the low five bits of the start address, and the full start address is the tag.

On the fetch side, a request gives a start address and a vector of predicted directions. Bit j of that vector is the prediction for the j-th branch of the trace. One cycle later the block returns four things: a hit flag, a per-slot valid mask, the instruction slots, and the address to fetch next. When a stored direction disagrees with a prediction, supply stops at that branch. The next address is then the path the prediction chose. When every stored branch agrees, the whole trace is delivered and the next address is the trace's recorded successor. Addresses count instruction words, so the fall-through of an instruction at address a is a+1.

Top module: `trace_cache`

## Requirements
- R1: After synchronous reset, `rsp_valid` is 0 and every line is empty, so any lookup misses.
- R2: A lookup presented with `lk_valid` in one cycle produces `rsp_valid`=1 exactly in the following cycle. `rsp_valid` is 0 in any cycle not preceded by a lookup.
- R3: A trace is closed when it reaches 16 instructions.
- R4: A trace is closed by its third conditional branch, and that branch is the trace's last slot.
- R5: An instruction with `ret_end`=1 closes the trace and is its last slot. The trace's successor address is that instruction's `ret_next`.
- R6: A trace becomes visible only after its closing instruction retires. A lookup issued in the cycle after the closing retire hits, and a lookup of a still-open trace misses.
- R7: A hit needs a filled line whose tag equals the full lookup address. On a miss, `rsp_hit`=0, `rsp_mask`=0, `rsp_next` equals the lookup address, and `rsp_insn` is 0.
- R8: If every stored branch agrees with `lk_pred`, `rsp_mask` has its low L bits set, where L is the trace length, and `rsp_next` is the successor address.
- R9: At the first branch j whose stored direction differs from `lk_pred[j]`, the mask covers slots 0 up to and including that branch. `rsp_next` is the branch target if `lk_pred[j]`=1, and the branch address plus 1 otherwise. Prediction bits beyond the trace's branch count are ignored.
- R10: A closed trace whose index is already occupied replaces the old line, so the old start address then misses.
- R11: `flush` discards the trace being built, together with any instruction retired in the same cycle. The next retired instruction starts a new trace at its own address.
- R12: Traces are not deduplicated: the same instructions may live in several lines with different start addresses, and each of those lines hits.
- R13: Slot s of `rsp_insn` occupies bits [32s+31:32s]. Slots outside `rsp_mask` read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard the trace being built |
| ret_valid | input | 1 | A retired instruction is presented |
| ret_pc | input | 16 | Address of the retired instruction |
| ret_insn | input | 32 | Instruction word |
| ret_br | input | 1 | Instruction is a conditional branch |
| ret_taken | input | 1 | Resolved direction of the branch |
| ret_tgt | input | 16 | Branch target address |
| ret_next | input | 16 | Address actually executed next |
| ret_end | input | 1 | Indirect jump or return; ends the trace |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 16 | Lookup start address |
| lk_pred | input | 3 | Predicted direction per branch, bit j for branch j |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_mask | output | 16 | Per-slot valid mask |
| rsp_insn | output | 512 | Instruction slots, slot s at bits [32s+31:32s] |
| rsp_next | output | 16 | Address to fetch next |

## Verification
Traces are formed in four ways: by the branch limit, by the length limit, by an ending jump that follows a branch, and by an ending jump alone. These show whether each closing rule counts correctly and includes the closing instruction. A three-branch trace is then probed with predictions that agree fully and with predictions that first disagree at branch 0, 1 and 2. Each case yields a distinct mask and next address, which separates the target path from the fall-through path and early cut points from late ones. Lookups of open traces, flushed traces, replaced lines and same-index aliases tell a correct fill timing and full tag compare from one that exposes partial or stale lines.

// File: rtl/tc_pkg.sv
package tc_pkg;
    localparam int AW     = 16;
    localparam int IW     = 32;
    localparam int N      = 16;
    localparam int B      = 3;
    localparam int LINES  = 32;
    localparam int SLOT_W = $clog2(N);
    localparam int CNT_W  = $clog2(N + 1);
    localparam int BRC_W  = $clog2(B + 1);
    localparam int IDX_W  = $clog2(LINES);

    typedef struct packed {
        logic                        vld;
        logic [AW-1:0]               tag;
        logic [CNT_W-1:0]            len;
        logic [BRC_W-1:0]            nbr;
        logic [B-1:0]                dir;
        logic [B-1:0][SLOT_W-1:0]    bpos;
        logic [B-1:0][AW-1:0]        btgt;
        logic [B-1:0][AW-1:0]        bfall;
        logic [AW-1:0]               succ;
        logic [N-1:0][IW-1:0]        insn;
    } line_t;

    function automatic logic [IDX_W-1:0] line_index(input logic [AW-1:0] a);
        return a[IDX_W-1:0];
    endfunction
endpackage

// File: rtl/tc_fill_unit.sv
module tc_fill_unit
    import tc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          ret_valid,
    input  logic [AW-1:0] ret_pc,
    input  logic [IW-1:0] ret_insn,
    input  logic          ret_br,
    input  logic          ret_taken,
    input  logic [AW-1:0] ret_tgt,
    input  logic [AW-1:0] ret_next,
    input  logic          ret_end,
    output logic          wr_en,
    output line_t         wr_line
);
    line_t cur;
    line_t app;
    logic  active;
    logic  close;

    always_comb begin
        app = cur;
        if (!active) begin
            app     = '0;
            app.tag = ret_pc;
        end
        app.vld = 1'b1;
        app.insn[app.len[SLOT_W-1:0]] = ret_insn;
        if (ret_br) begin
            app.dir[app.nbr]   = ret_taken;
            app.bpos[app.nbr]  = app.len[SLOT_W-1:0];
            app.btgt[app.nbr]  = ret_tgt;
            app.bfall[app.nbr] = ret_pc + AW'(1);
            app.nbr            = app.nbr + BRC_W'(1);
        end
        app.len  = app.len + CNT_W'(1);
        app.succ = ret_next;
        close    = (app.len == CNT_W'(N)) || (app.nbr == BRC_W'(B)) || ret_end;
        wr_en    = ret_valid && !flush && close;
        wr_line  = app;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            active <= 1'b0;
            cur    <= '0;
        end else if (ret_valid) begin
            if (close) begin
                active <= 1'b0;
            end else begin
                active <= 1'b1;
                cur    <= app;
            end
        end
    end

    assert_open_len_R3: assert property (@(posedge clk) disable iff (rst)
        active |-> (cur.len < CNT_W'(N)));
    assert_open_branches_R4: assert property (@(posedge clk) disable iff (rst)
        active |-> (cur.nbr < BRC_W'(B)));
    assert_closed_after_write_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !active);
endmodule

// File: rtl/tc_line_store.sv
module tc_line_store
    import tc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  line_t         wr_line,
    input  logic [AW-1:0] rd_addr,
    output line_t         rd_line
);
    line_t             mem [LINES];
    logic [LINES-1:0]  vld;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;

    assign wr_idx = line_index(wr_line.tag);
    assign rd_idx = line_index(rd_addr);

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_line;
    end

    always_ff @(posedge clk) begin
        if (rst)        vld <= '0;
        else if (wr_en) vld[wr_idx] <= 1'b1;
    end

    always_comb begin
        rd_line     = mem[rd_idx];
        rd_line.vld = vld[rd_idx];
    end

    assert_fill_visible_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> vld[$past(wr_idx)]);
endmodule

// File: rtl/tc_matcher.sv
module tc_matcher
    import tc_pkg::*;
(
    input  line_t                ln,
    input  logic [AW-1:0]        addr,
    input  logic [B-1:0]         pred,
    output logic                 hit,
    output logic [N-1:0]         mask,
    output logic [AW-1:0]        next,
    output logic [N-1:0][IW-1:0] insn
);
    logic             found;
    logic [CNT_W-1:0] limit;

    always_comb begin
        hit   = ln.vld && (ln.tag == addr);
        found = 1'b0;
        limit = ln.len;
        next  = ln.succ;
        for (int j = 0; j < B; j++) begin
            if (!found && (BRC_W'(j) < ln.nbr) && (ln.dir[j] != pred[j])) begin
                found = 1'b1;
                limit = CNT_W'(ln.bpos[j]) + CNT_W'(1);
                next  = pred[j] ? ln.btgt[j] : ln.bfall[j];
            end
        end
        if (!hit) next = addr;
        for (int s = 0; s < N; s++) begin
            mask[s] = hit && (CNT_W'(s) < limit);
            insn[s] = mask[s] ? ln.insn[s] : '0;
        end
    end
endmodule

// File: rtl/trace_cache.sv
module trace_cache
    import tc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic            ret_valid,
    input  logic [AW-1:0]   ret_pc,
    input  logic [IW-1:0]   ret_insn,
    input  logic            ret_br,
    input  logic            ret_taken,
    input  logic [AW-1:0]   ret_tgt,
    input  logic [AW-1:0]   ret_next,
    input  logic            ret_end,
    input  logic            lk_valid,
    input  logic [AW-1:0]   lk_addr,
    input  logic [B-1:0]    lk_pred,
    output logic            rsp_valid,
    output logic            rsp_hit,
    output logic [N-1:0]    rsp_mask,
    output logic [N*IW-1:0] rsp_insn,
    output logic [AW-1:0]   rsp_next
);
    logic                 wr_en;
    line_t                wr_line;
    line_t                rd_line;
    logic                 m_hit;
    logic [N-1:0]         m_mask;
    logic [AW-1:0]        m_next;
    logic [N-1:0][IW-1:0] m_insn;

    tc_fill_unit u_fill (
        .clk(clk), .rst(rst), .flush(flush),
        .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_insn(ret_insn),
        .ret_br(ret_br), .ret_taken(ret_taken), .ret_tgt(ret_tgt),
        .ret_next(ret_next), .ret_end(ret_end),
        .wr_en(wr_en), .wr_line(wr_line)
    );

    tc_line_store u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_line(wr_line),
        .rd_addr(lk_addr), .rd_line(rd_line)
    );

    tc_matcher u_match (
        .ln(rd_line), .addr(lk_addr), .pred(lk_pred),
        .hit(m_hit), .mask(m_mask), .next(m_next), .insn(m_insn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_mask  <= '0;
            rsp_insn  <= '0;
            rsp_next  <= '0;
        end else begin
            rsp_valid <= lk_valid;
            if (lk_valid) begin
                rsp_hit  <= m_hit;
                rsp_mask <= m_mask;
                rsp_insn <= m_insn;
                rsp_next <= m_next;
            end
        end
    end

    assert_rsp_timing_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(lk_valid));
    assert_miss_empty_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_mask == '0));
    assert_mask_prefix_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ((rsp_mask & (rsp_mask + N'(1))) == '0));
    assert_hit_first_slot_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> rsp_mask[0]);
endmodule

// File: tb/test_trace_cache.sv
module test_trace_cache;
    localparam int AW = 16;
    localparam int IW = 32;
    localparam int N  = 16;
    localparam int VW = N * IW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          flush = 1'b0;
    logic          ret_valid = 1'b0;
    logic [AW-1:0] ret_pc = '0;
    logic [IW-1:0] ret_insn = '0;
    logic          ret_br = 1'b0;
    logic          ret_taken = 1'b0;
    logic [AW-1:0] ret_tgt = '0;
    logic [AW-1:0] ret_next = '0;
    logic          ret_end = 1'b0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic [2:0]    lk_pred = '0;
    logic          rsp_valid;
    logic          rsp_hit;
    logic [N-1:0]  rsp_mask;
    logic [VW-1:0] rsp_insn;
    logic [AW-1:0] rsp_next;

    int n_checks = 0;
    int n_fail   = 0;

    logic [AW-1:0] seq_pc [N];
    int            seq_n;

    always #10 clk = ~clk;

    trace_cache i_trace_cache (
        .clk(clk), .rst(rst), .flush(flush),
        .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_insn(ret_insn),
        .ret_br(ret_br), .ret_taken(ret_taken), .ret_tgt(ret_tgt),
        .ret_next(ret_next), .ret_end(ret_end),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_pred(lk_pred),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_mask(rsp_mask),
        .rsp_insn(rsp_insn), .rsp_next(rsp_next)
    );

    function automatic logic [IW-1:0] insn_of(input logic [AW-1:0] pc);
        return 32'hC0DE_0000 ^ {16'h0, pc} ^ {pc, 16'h0};
    endfunction

    function automatic logic [VW-1:0] exp_vec(input int k);
        logic [VW-1:0] v = '0;
        for (int s = 0; s < k; s++) v[s*IW +: IW] = insn_of(seq_pc[s]);
        return v;
    endfunction

    task automatic check(input string what, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic rec_clear();
        seq_n = 0;
    endtask

    task automatic retire(input logic [AW-1:0] pc, input logic br, input logic tk,
                          input logic [AW-1:0] tgt, input logic [AW-1:0] nxt, input logic en);
        @(negedge clk);
        ret_valid = 1'b1; ret_pc = pc; ret_insn = insn_of(pc);
        ret_br = br; ret_taken = tk; ret_tgt = tgt; ret_next = nxt; ret_end = en;
        @(negedge clk);
        ret_valid = 1'b0; ret_br = 1'b0; ret_end = 1'b0;
        if (seq_n < N) begin
            seq_pc[seq_n] = pc;
            seq_n++;
        end
    endtask

    task automatic plain(input logic [AW-1:0] pc);
        retire(pc, 1'b0, 1'b0, '0, pc + 16'd1, 1'b0);
    endtask

    task automatic lookup(input logic [AW-1:0] a, input logic [2:0] p);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; lk_pred = p;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic expect_hit(input string r, input logic [N-1:0] m, input int k, input logic [AW-1:0] nx);
        check({r, " rsp_valid"}, VW'(rsp_valid), VW'(1));
        check({r, " hit"}, VW'(rsp_hit), VW'(1));
        check({r, " mask"}, VW'(rsp_mask), VW'(m));
        check({r, " next"}, VW'(rsp_next), VW'(nx));
        check({r, " insn slots"}, rsp_insn, exp_vec(k));
    endtask

    task automatic expect_miss(input string r, input logic [AW-1:0] a);
        check({r, " miss hit"}, VW'(rsp_hit), VW'(0));
        check({r, " miss mask"}, VW'(rsp_mask), VW'(0));
        check({r, " miss next"}, VW'(rsp_next), VW'(a));
        check({r, " miss insn"}, rsp_insn, '0);
    endtask

    task automatic t_reset();
        check("R1 rsp_valid after reset", VW'(rsp_valid), VW'(0));
        lookup(16'h0040, 3'b000);
        check("R2 response one cycle after lookup", VW'(rsp_valid), VW'(1));
        expect_miss("R1", 16'h0040);
        @(negedge clk);
        check("R2 rsp_valid drops without lookup", VW'(rsp_valid), VW'(0));
    endtask

    task automatic t_branch_limit();
        rec_clear();
        retire(16'h0100, 1'b1, 1'b1, 16'h0120, 16'h0120, 1'b0);
        plain(16'h0120);
        retire(16'h0121, 1'b1, 1'b0, 16'h0200, 16'h0122, 1'b0);
        plain(16'h0122);
        lookup(16'h0100, 3'b101);
        expect_miss("R6 open trace", 16'h0100);
        retire(16'h0123, 1'b1, 1'b1, 16'h0300, 16'h0300, 1'b0);
        lookup(16'h0100, 3'b101);
        expect_hit("R4 R8 full match", 16'h001F, 5, 16'h0300);
        lookup(16'h0100, 3'b001);
        expect_hit("R9 mismatch branch2 fallthrough", 16'h001F, 5, 16'h0124);
        lookup(16'h0100, 3'b111);
        expect_hit("R9 mismatch branch1 target", 16'h0007, 3, 16'h0200);
        lookup(16'h0100, 3'b000);
        expect_hit("R9 mismatch branch0 fallthrough R13", 16'h0001, 1, 16'h0101);
        lookup(16'h0120, 3'b101);
        expect_miss("R7 same index other tag", 16'h0120);
    endtask

    task automatic t_length_limit_and_flush();
        rec_clear();
        for (int i = 0; i < 15; i++) plain(16'h0041 + 16'(i));
        lookup(16'h0041, 3'b000);
        expect_miss("R6 fifteen insns open", 16'h0041);
        plain(16'h0050);
        lookup(16'h0041, 3'b000);
        expect_hit("R3 sixteen insns", 16'hFFFF, 16, 16'h0051);
        plain(16'h0051);
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        rec_clear();
        plain(16'h0052);
        retire(16'h0053, 1'b0, 1'b0, '0, 16'h0777, 1'b1);
        lookup(16'h0051, 3'b000);
        expect_miss("R11 flushed start", 16'h0051);
        lookup(16'h0052, 3'b111);
        expect_hit("R11 R5 new trace after flush", 16'h0003, 2, 16'h0777);
    endtask

    task automatic t_end_after_branch();
        rec_clear();
        retire(16'h0062, 1'b1, 1'b0, 16'h0090, 16'h0063, 1'b0);
        retire(16'h0063, 1'b0, 1'b0, '0, 16'h0500, 1'b1);
        lookup(16'h0062, 3'b110);
        expect_hit("R5 end closes R9 extra preds ignored", 16'h0003, 2, 16'h0500);
        lookup(16'h0062, 3'b001);
        expect_hit("R9 predicted taken goes to target", 16'h0001, 1, 16'h0090);
    endtask

    task automatic t_replace();
        rec_clear();
        retire(16'h0020, 1'b0, 1'b0, '0, 16'h0044, 1'b1);
        lookup(16'h0020, 3'b000);
        expect_hit("R10 new line", 16'h0001, 1, 16'h0044);
        lookup(16'h0100, 3'b101);
        expect_miss("R10 replaced line", 16'h0100);
    endtask

    task automatic t_duplicate();
        rec_clear();
        plain(16'h00A3);
        retire(16'h00A4, 1'b0, 1'b0, '0, 16'h0010, 1'b1);
        rec_clear();
        retire(16'h00A4, 1'b0, 1'b0, '0, 16'h0010, 1'b1);
        lookup(16'h00A4, 3'b000);
        expect_hit("R12 short copy", 16'h0001, 1, 16'h0010);
        seq_pc[0] = 16'h00A3; seq_pc[1] = 16'h00A4;
        lookup(16'h00A3, 3'b000);
        expect_hit("R12 long copy", 16'h0003, 2, 16'h0010);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        seq_n = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_branch_limit();
        t_length_limit_and_flush();
        t_end_after_branch();
        t_replace();
        t_duplicate();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule